// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit sits between instruction decode and the memory port of a 32-bit load/store processor. Each cycle with `req_valid` high it takes a base register value, the current instruction address, an immediate and a shifted register offset. From these it forms the effective address of the access and the second address of a paired-word transfer. It also returns the value to write back to the base register and tells whether that write-back should happen. A misaligned halfword or word access raises a fault flag.

Results are registered: they appear one cycle after the request and stay stable until the next request. The offset comes from the immediate or from a register shifted left by 0 to 31 bits. It is added or subtracted according to a direction flag. All arithmetic wraps modulo 2^32.

Top module: `agu_top`

## Requirements
- R1: Mode 0 (indirect): `ea` equals `base`, `wb_en` is 0 and `wb_val` equals `base`.
- R2: Mode 1 (offset): `ea` equals `base + off`, or `base - off` when `sub_off` is 1; `wb_en` is 0.
- R3: Mode 2 (pre-indexed): `ea` equals `base ± off`, `wb_val` equals `ea` and `wb_en` is 1.
- R4: Mode 3 (post-indexed): `ea` equals `base`, `wb_val` equals `base ± off` and `wb_en` is 1.
- R5: With `off_sel` = 0 the offset `off` is `imm`. With `off_sel` = 1 it is `roff` shifted left logically by `shamt` (0 to 31), and bits shifted past bit 31 are lost.
- R6: Mode 4 (PC-relative): `ea` equals `((pc + 4) with bits [1:0] cleared) ± off`, and `wb_en` is 0.
- R7: Mode 5 (absolute): `ea` equals `imm` whatever `off_sel`, `sub_off`, `base` and `pc` are, and `wb_en` is 0.
- R8: `ea2` always equals `ea + 4` modulo 2^32.
- R9: `align_fault` is 1 when a halfword access (`size` = 01) has `ea[0]` set, or when a word access (`size` = 1x, or any `size` with `pair` = 1) has `ea[1:0]` nonzero. A byte access (`size` = 00, `pair` = 0) never faults.
- R10: Additions and subtractions wrap modulo 2^32, and no overflow is signalled.
- R11: Outputs update on the clock edge after a cycle with `req_valid` = 1, and `out_valid` is 1 in the following cycle. After a cycle with `req_valid` = 0, `out_valid`, `wb_en` and `align_fault` are 0 and `ea`, `ea2` and `wb_val` keep their values.
- R12: While `rst_n` is low, every output is 0.
- R13: Modes 6 and 7 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode, encoded as in R1 to R7 and R13 |
| sub_off | input | 1 | Subtract the offset instead of adding it |
| off_sel | input | 1 | 0: immediate offset, 1: shifted register offset |
| size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| pair | input | 1 | Paired-word access |
| base | input | 32 | Base register value |
| pc | input | 32 | Current instruction address |
| imm | input | 32 | Immediate offset or absolute literal |
| roff | input | 32 | Offset register value |
| shamt | input | 5 | Left shift applied to `roff` |
| out_valid | output | 1 | Registered results valid |
| ea | output | 32 | Effective (first) address |
| ea2 | output | 32 | Second address of a paired access |
| wb_val | output | 32 | Value for base register write-back |
| wb_en | output | 1 | Base write-back required |
| align_fault | output | 1 | Misaligned halfword or word access |

## Verification
The hardest case to reach is an address that crosses zero. A subtraction must pass below zero, or a post-index step must carry out of bit 31, while the alignment check still sees the wrapped low bits. Random operands almost never land there. Directed steps therefore put `base` or `pc` next to 0 or 0xFFFFFFFF and subtract an offset larger than the base, with a register offset shifted by 31. PC values with low bits set exercise the rounding in R6. These steps are mixed with idle cycles, so that the held outputs are checked right after a wrapped result.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_INDIRECT = 3'd0,
    AM_OFFSET   = 3'd1,
    AM_PRE      = 3'd2,
    AM_POST     = 3'd3,
    AM_PCREL    = 3'd4,
    AM_ABS      = 3'd5
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } asize_e;

endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
  parameter int AW = 32,
  localparam int SHW = $clog2(AW)
) (
  input  logic           off_sel,
  input  logic [AW-1:0]  imm,
  input  logic [AW-1:0]  roff,
  input  logic [SHW-1:0] shamt,
  output logic [AW-1:0]  off
);

  always_comb begin
    if (off_sel) off = roff << shamt;
    else         off = imm;
  end

endmodule

// File: rtl/agu_addr.sv
module agu_addr
  import agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int PC_STEP = 4,
  parameter int ALIGN_BITS = 2
) (
  input  amode_e        mode,
  input  logic          sub_off,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] imm,
  input  logic [AW-1:0] off,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] wb_val,
  output logic          wb_en
);

  localparam logic [AW-1:0] STEP = AW'(PC_STEP);
  localparam logic [AW-1:0] PC_MASK = ~((AW'(1) << ALIGN_BITS) - AW'(1));

  logic [AW-1:0] pc_src;
  logic [AW-1:0] src;
  logic [AW-1:0] moved;

  always_comb begin
    pc_src = (pc + STEP) & PC_MASK;
    src    = (mode == AM_PCREL) ? pc_src : base;
    moved  = sub_off ? (src - off) : (src + off);
  end

  always_comb begin
    ea     = base;
    wb_val = base;
    wb_en  = 1'b0;
    unique case (mode)
      AM_OFFSET: ea = moved;
      AM_PRE: begin
        ea     = moved;
        wb_val = moved;
        wb_en  = 1'b1;
      end
      AM_POST: begin
        wb_val = moved;
        wb_en  = 1'b1;
      end
      AM_PCREL: ea = moved;
      AM_ABS:   ea = imm;
      default:  ea = base;
    endcase
  end

endmodule

// File: rtl/agu_align.sv
module agu_align
  import agu_pkg::*;
(
  input  asize_e     size,
  input  logic       pair,
  input  logic [1:0] low,
  output logic       fault
);

  always_comb begin
    if (pair || size == SZ_WORD || size == SZ_WRD2) fault = |low;
    else if (size == SZ_HALF)                       fault = low[0];
    else                                            fault = 1'b0;
  end

endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW = 32,
  localparam int SHW = $clog2(AW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [2:0]     mode,
  input  logic           sub_off,
  input  logic           off_sel,
  input  logic [1:0]     size,
  input  logic           pair,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  pc,
  input  logic [AW-1:0]  imm,
  input  logic [AW-1:0]  roff,
  input  logic [SHW-1:0] shamt,
  output logic           out_valid,
  output logic [AW-1:0]  ea,
  output logic [AW-1:0]  ea2,
  output logic [AW-1:0]  wb_val,
  output logic           wb_en,
  output logic           align_fault
);

  localparam logic [AW-1:0] PAIR_STEP = AW'(4);

  logic [AW-1:0] off_c;
  logic [AW-1:0] ea_c;
  logic [AW-1:0] wbv_c;
  logic          wbe_c;
  logic          flt_c;

  logic [AW-1:0] ea_d, ea2_d, wbv_d;
  logic          vld_d, wbe_d, flt_d;

  agu_offset #(.AW(AW)) u_off (
    .off_sel (off_sel),
    .imm     (imm),
    .roff    (roff),
    .shamt   (shamt),
    .off     (off_c)
  );

  agu_addr #(.AW(AW)) u_addr (
    .mode    (amode_e'(mode)),
    .sub_off (sub_off),
    .base    (base),
    .pc      (pc),
    .imm     (imm),
    .off     (off_c),
    .ea      (ea_c),
    .wb_val  (wbv_c),
    .wb_en   (wbe_c)
  );

  agu_align u_align (
    .size  (asize_e'(size)),
    .pair  (pair),
    .low   (ea_c[1:0]),
    .fault (flt_c)
  );

  // next state
  always_comb begin
    vld_d = req_valid;
    wbe_d = req_valid & wbe_c;
    flt_d = req_valid & flt_c;
    ea_d  = ea;
    ea2_d = ea2;
    wbv_d = wb_val;
    if (req_valid) begin
      ea_d  = ea_c;
      ea2_d = ea_c + PAIR_STEP;
      wbv_d = wbv_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      wb_en       <= 1'b0;
      align_fault <= 1'b0;
      ea          <= '0;
      ea2         <= '0;
      wb_val      <= '0;
    end else begin
      out_valid   <= vld_d;
      wb_en       <= wbe_d;
      align_fault <= flt_d;
      ea          <= ea_d;
      ea2         <= ea2_d;
      wb_val      <= wbv_d;
    end
  end

endmodule

// File: rtl/agu_chk.sv
module agu_chk
  import agu_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    mode,
  input logic          off_sel,
  input logic [1:0]    size,
  input logic          pair,
  input logic [AW-1:0] base,
  input logic [AW-1:0] imm,
  input logic          out_valid,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] ea2,
  input logic [AW-1:0] wb_val,
  input logic          wb_en,
  input logic          align_fault
);

  AST_INDIRECT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mode) == 3'd0 |-> ea == $past(base) && !wb_en); // R1

  AST_PRE_WRITES_EA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mode) == 3'd2 |-> wb_en && wb_val == ea); // R3

  AST_POST_USES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mode) == 3'd3 |-> wb_en && ea == $past(base)); // R4

  AST_PCREL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mode) == 3'd4 && !$past(off_sel) && $past(imm[1:0]) == 2'b00
    |-> ea[1:0] == 2'b00 && !wb_en); // R6

  AST_ABS_LITERAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mode) == 3'd5 |-> ea == $past(imm) && !wb_en); // R7

  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ea2 == ea + AW'(4)); // R8

  AST_HALF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(size) == 2'b01 && !$past(pair) |-> align_fault == ea[0]); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && !wb_en && !align_fault && $stable(ea) && $stable(wb_val)); // R11

endmodule

bind agu_top agu_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .mode        (mode),
  .off_sel     (off_sel),
  .size        (size),
  .pair        (pair),
  .base        (base),
  .imm         (imm),
  .out_valid   (out_valid),
  .ea          (ea),
  .ea2         (ea2),
  .wb_val      (wb_val),
  .wb_en       (wb_en),
  .align_fault (align_fault)
);

// File: tb/agu_top_tb.sv
`timescale 1ns/1ps
module agu_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic        sub_off = 1'b0;
  logic        off_sel = 1'b0;
  logic [1:0]  size = '0;
  logic        pair = 1'b0;
  logic [31:0] base = '0, pc = '0, imm = '0, roff = '0;
  logic [4:0]  shamt = '0;
  logic        out_valid, wb_en, align_fault;
  logic [31:0] ea, ea2, wb_val;

  int total = 0;
  int bad = 0;

  // expected values for the outputs after the last driven step
  logic        x_vld = 0, x_wbe = 0, x_flt = 0;
  logic [31:0] x_ea = 0, x_ea2 = 0, x_wbv = 0;
  string       x_tag = "R12";

  always #10 clk = ~clk;

  agu_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .sub_off(sub_off), .off_sel(off_sel), .size(size), .pair(pair),
    .base(base), .pc(pc), .imm(imm), .roff(roff), .shamt(shamt),
    .out_valid(out_valid), .ea(ea), .ea2(ea2), .wb_val(wb_val),
    .wb_en(wb_en), .align_fault(align_fault)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(x_tag, "out_valid", 32'(out_valid), 32'(x_vld));
    chk(x_tag, "ea", ea, x_ea);
    chk("R8", "ea2", ea2, x_ea2);
    chk(x_tag, "wb_val", wb_val, x_wbv);
    chk(x_tag, "wb_en", 32'(wb_en), 32'(x_wbe));
    chk("R9", "align_fault", 32'(align_fault), 32'(x_flt));
  endtask

  // behavioural reference, built from the requirement text
  task automatic model(string force_tag);
    longint unsigned o, s, a, w;
    int m;
    bit we;
    m = (mode > 3'd5) ? 0 : int'(mode);
    o = off_sel ? ((longint'(roff) << shamt) % 64'h1_0000_0000) : longint'(imm);
    s = (m == 4) ? ((longint'(pc) + 4) % 64'h1_0000_0000) / 4 * 4 : longint'(base);
    if (sub_off) w = (s + 64'h1_0000_0000 - o) % 64'h1_0000_0000;
    else         w = (s + o) % 64'h1_0000_0000;
    a = longint'(base); we = 0;
    case (m)
      1: a = w;
      2: begin a = w; we = 1; end
      3: we = 1;
      4: a = w;
      5: a = longint'(imm);
      default: ;
    endcase
    if (req_valid) begin
      x_vld = 1; x_wbe = we;
      x_ea = 32'(a); x_ea2 = 32'((a + 4) % 64'h1_0000_0000);
      x_wbv = (m == 2 || m == 3) ? 32'(w) : base;
      if (pair || size[1]) x_flt = (a % 4) != 0;
      else if (size == 2'b01) x_flt = (a % 2) != 0;
      else x_flt = 0;
      case (m)
        0: x_tag = (mode > 3'd5) ? "R13" : "R1";
        1: x_tag = "R2";
        2: x_tag = "R3";
        3: x_tag = "R4";
        4: x_tag = "R6";
        default: x_tag = "R7";
      endcase
      if (off_sel && m >= 1 && m <= 4) x_tag = "R5";
    end else begin
      x_vld = 0; x_wbe = 0; x_flt = 0; x_tag = "R11";
    end
    if (force_tag != "") x_tag = force_tag;
  endtask

  task automatic step(bit v, logic [2:0] md, bit sb, bit os, logic [1:0] sz, bit pr,
                      logic [31:0] b, logic [31:0] p, logic [31:0] im,
                      logic [31:0] ro, logic [4:0] sh, string tg);
    @(negedge clk);
    compare_all();
    req_valid = v; mode = md; sub_off = sb; off_sel = os; size = sz; pair = pr;
    base = b; pc = p; imm = im; roff = ro; shamt = sh;
    model(tg);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all(); // R12 reset state
    rst_n = 1'b1;
    // directed corners
    step(1, 3'd0, 0, 0, 2'b10, 0, 32'h1000, 0, 32'h55, 0, 0, "R1");
    step(1, 3'd1, 0, 0, 2'b10, 0, 32'h1000, 0, 32'h8, 0, 0, "R2");
    step(1, 3'd1, 1, 0, 2'b10, 0, 32'h1000, 0, 32'h8, 0, 0, "R2");
    step(1, 3'd2, 0, 0, 2'b10, 0, 32'h2000, 0, 32'h10, 0, 0, "R3");
    step(1, 3'd3, 1, 0, 2'b10, 0, 32'h2000, 0, 32'h10, 0, 0, "R4");
    step(1, 3'd1, 0, 1, 2'b10, 0, 32'h0, 0, 0, 32'h3, 5'd3, "R5");
    step(1, 3'd1, 0, 1, 2'b00, 0, 32'h10, 0, 0, 32'h3, 5'd31, "R5");
    step(1, 3'd4, 0, 0, 2'b10, 0, 32'hDEAD, 32'h103, 32'h8, 0, 0, "R6");
    step(1, 3'd4, 1, 0, 2'b10, 0, 0, 32'hFFFF_FFFE, 32'h4, 0, 0, "R6");
    step(1, 3'd5, 1, 1, 2'b10, 0, 32'h77, 32'h99, 32'h4000, 32'hF, 5'd2, "R7");
    step(1, 3'd1, 1, 0, 2'b10, 0, 32'h4, 0, 32'h10, 0, 0, "R10");
    step(1, 3'd3, 0, 0, 2'b10, 0, 32'hFFFF_FFFC, 0, 32'h8, 0, 0, "R10");
    step(1, 3'd2, 1, 1, 2'b10, 0, 32'h0, 0, 0, 32'h1, 5'd31, "R10");
    step(0, 3'd2, 0, 0, 2'b10, 0, 32'h1, 0, 32'h1, 0, 0, "R11");
    step(0, 3'd1, 0, 0, 2'b01, 0, 32'h3, 0, 32'h3, 0, 0, "R11");
    step(1, 3'd0, 0, 0, 2'b01, 0, 32'h3, 0, 0, 0, 0, "R9");
    step(1, 3'd0, 0, 0, 2'b01, 0, 32'h2, 0, 0, 0, 0, "R9");
    step(1, 3'd0, 0, 0, 2'b00, 0, 32'h3, 0, 0, 0, 0, "R9");
    step(1, 3'd0, 0, 0, 2'b00, 1, 32'h2, 0, 0, 0, 0, "R9");
    step(1, 3'd0, 0, 0, 2'b11, 0, 32'h1, 0, 0, 0, 0, "R9");
    step(1, 3'd6, 0, 0, 2'b10, 0, 32'h44, 0, 32'h8, 0, 0, "R13");
    step(1, 3'd7, 1, 1, 2'b10, 0, 32'h48, 0, 32'h8, 32'h1, 5'd4, "R13");
    step(1, 3'd4, 0, 1, 2'b10, 1, 0, 32'h8, 0, 32'h5, 5'd2, "R5");
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, 3'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), 1'($urandom), $urandom, $urandom,
           (($urandom % 3) == 0) ? 32'($urandom % 16) : $urandom,
           $urandom, 5'($urandom), "");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    @(negedge clk);
    compare_all();
    rst_n = 1'b0;
    x_vld = 0; x_wbe = 0; x_flt = 0; x_ea = 0; x_ea2 = 0; x_wbv = 0; x_tag = "R12";
    @(negedge clk);
    compare_all(); // R12 reset clears outputs mid-run
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule